// File: doc/BRIEF.md
# Branch Resolution and Link Unit

This block resolves four decoded branch instructions of a 32-bit mainframe-style instruction set: conditional branch in register and indexed form, and branch-with-link in register and indexed form. The issue stage presents the decoded fields, the register values already read, the current condition code, the program mask, the instruction length code and the 24-bit address of the current instruction. One cycle later the block reports whether the branch is taken, the 24-bit address that replaces the instruction address, and an optional write of a link word into a general register.

The condition test uses a 4-bit mask held in the first register field. The most significant mask bit stands for condition code 0 and the least significant for code 3. A register field of zero in an index, base or second-register position means that no operand is present; it never reads register 0. The link destination, however, may be register 0. The link word holds the return address in its low 24 bits and packs machine state above it, so that a later routine can inspect the condition code.

Top module: `br_resolve_unit`

## Requirements
- R1: For conditional opcodes, the branch is taken exactly when mask bit `3-cc` is set (mask weight 8 tests code 0, 4 tests code 1, 2 tests code 2, 1 tests code 3).
- R2: A mask of 4'hF always branches and a mask of 4'h0 never branches.
- R3: Indexed forms (opcodes 8'h47 and 8'h45) target disp + X + B modulo 2^24, using only the low 24 bits of each register, and an X or B field of zero contributes zero.
- R4: Register forms (opcodes 8'h07 and 8'h05) target the low 24 bits of the R2 register, and an R2 field of zero suppresses the branch.
- R5: Link opcodes 8'h45 and 8'h05 always write the link word to the register named by the R1 field, register 0 included; 8'h45 always branches, and 8'h05 branches only when its R2 field is non-zero but links in either case.
- R6: The link word is {ilc[1:0], cc[1:0], pmask[3:0], return[23:0]}, with ilc in bits 31:30, where return = address + 2*ilc modulo 2^24.
- R7: Any opcode other than 8'h05, 8'h07, 8'h45 and 8'h47, and any cycle with `i_valid` low, gives no branch and no link write.
- R8: Outputs appear one clock after an issue and last one cycle. When not taken, `o_target` is 0. Without a link write, `o_link_sel` and `o_link_data` are 0.
- R9: A synchronous active-high reset clears all outputs, and an issue during reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | A decoded instruction is issued this cycle |
| i_opcode | input | 8 | Opcode byte |
| i_r1 | input | 4 | Mask (conditional) or link register (linking) |
| i_x2 | input | 4 | Index register field, 0 = none |
| i_b2 | input | 4 | Base register field, 0 = none |
| i_r2 | input | 4 | Second register field, 0 = none |
| i_disp | input | 12 | Displacement |
| i_x_data | input | 32 | Value of the index register |
| i_b_data | input | 32 | Value of the base register |
| i_r2_data | input | 32 | Value of the R2 register |
| i_cc | input | 2 | Current condition code |
| i_pmask | input | 4 | Program mask |
| i_ilc | input | 2 | Instruction length code (length = 2*ilc bytes) |
| i_iaddr | input | 24 | Address of the current instruction |
| o_taken | output | 1 | Branch taken |
| o_target | output | 24 | New instruction address |
| o_link_we | output | 1 | Link register write enable |
| o_link_sel | output | 4 | Link register number |
| o_link_data | output | 32 | Link word |

## Verification
A linking branch can produce a taken branch and a register write in the same output cycle. The register form with R2 set to zero splits the two, giving a write with no branch. The bench provokes both cases with link destination 0, with return addresses that wrap past 2^24, and in back-to-back issues with no idle cycle between them. A behavioural reference model compares the branch flag, target, write enable, destination and link word on every clock, so a cycle with a branch but no link, or a link with a stale target, is reported.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam logic [7:0] OP_BALR = 8'h05;
  localparam logic [7:0] OP_BCR  = 8'h07;
  localparam logic [7:0] OP_BAL  = 8'h45;
  localparam logic [7:0] OP_BC   = 8'h47;

  typedef enum logic [2:0] {
    K_NONE,
    K_COND_REG,
    K_LINK_REG,
    K_COND_IDX,
    K_LINK_IDX
  } br_kind_e;

  function automatic br_kind_e classify(input logic [7:0] op);
    case (op)
      OP_BCR:  return K_COND_REG;
      OP_BALR: return K_LINK_REG;
      OP_BC:   return K_COND_IDX;
      OP_BAL:  return K_LINK_IDX;
      default: return K_NONE;
    endcase
  endfunction
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval #(
  parameter int CCW = 2
) (
  input  logic [(2**CCW)-1:0] mask,
  input  logic [CCW-1:0]      cc,
  output logic                hit
);
  localparam int NM = 2**CCW;

  logic [NM-1:0] sel;

  // mask bit NM-1 tests code 0, bit 0 tests code NM-1
  for (genvar i = 0; i < NM; i++) begin : g_sel
    assign sel[i] = (cc == CCW'(NM - 1 - i));
  end

  assign hit = |(sel & mask);
endmodule

// File: rtl/br_addr_gen.sv
module br_addr_gen #(
  parameter int AW    = 24,
  parameter int DW    = 32,
  parameter int DISPW = 12,
  parameter int RIW   = 4
) (
  input  logic             indexed,
  input  logic [RIW-1:0]   x_fld,
  input  logic [RIW-1:0]   b_fld,
  input  logic [RIW-1:0]   r2_fld,
  input  logic [DW-1:0]    x_data,
  input  logic [DW-1:0]    b_data,
  input  logic [DW-1:0]    r2_data,
  input  logic [DISPW-1:0] disp,
  output logic [AW-1:0]    target,
  output logic             r2_present
);
  localparam int NOPND = 2;

  logic [RIW-1:0] fld  [NOPND];
  logic [DW-1:0]  data [NOPND];
  logic [AW-1:0]  opnd [NOPND];
  logic [AW-1:0]  idx_sum;
  logic           unused_hi;

  assign fld[0]  = x_fld;
  assign fld[1]  = b_fld;
  assign data[0] = x_data;
  assign data[1] = b_data;

  // a zero field names no operand
  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    assign opnd[g] = (fld[g] != '0) ? data[g][AW-1:0] : '0;
  end

  assign idx_sum    = {{(AW-DISPW){1'b0}}, disp} + opnd[0] + opnd[1];
  assign r2_present = (r2_fld != '0);
  assign target     = indexed ? idx_sum : r2_data[AW-1:0];
  assign unused_hi  = ^{x_data[DW-1:AW], b_data[DW-1:AW], r2_data[DW-1:AW]};
endmodule

// File: rtl/br_link_pack.sv
module br_link_pack #(
  parameter int AW   = 24,
  parameter int DW   = 32,
  parameter int CCW  = 2,
  parameter int PMW  = 4,
  parameter int ILCW = 2
) (
  input  logic [AW-1:0]   cur_addr,
  input  logic [ILCW-1:0] ilc,
  input  logic [CCW-1:0]  cc,
  input  logic [PMW-1:0]  pmask,
  output logic [DW-1:0]   word
);
  localparam int SW = ILCW + CCW + PMW;

  logic [AW-1:0] ret_addr;

  assign ret_addr = cur_addr + AW'({ilc, 1'b0});

  if (SW + AW == DW) begin : g_exact
    assign word = {ilc, cc, pmask, ret_addr};
  end else begin : g_pad
    assign word = {{(DW-SW-AW){1'b0}}, ilc, cc, pmask, ret_addr};
  end
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit #(
  parameter int AW    = 24,
  parameter int DW    = 32,
  parameter int DISPW = 12,
  parameter int RIW   = 4,
  parameter int CCW   = 2,
  parameter int PMW   = 4,
  parameter int ILCW  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_valid,
  input  logic [7:0]       i_opcode,
  input  logic [RIW-1:0]   i_r1,
  input  logic [RIW-1:0]   i_x2,
  input  logic [RIW-1:0]   i_b2,
  input  logic [RIW-1:0]   i_r2,
  input  logic [DISPW-1:0] i_disp,
  input  logic [DW-1:0]    i_x_data,
  input  logic [DW-1:0]    i_b_data,
  input  logic [DW-1:0]    i_r2_data,
  input  logic [CCW-1:0]   i_cc,
  input  logic [PMW-1:0]   i_pmask,
  input  logic [ILCW-1:0]  i_ilc,
  input  logic [AW-1:0]    i_iaddr,
  output logic             o_taken,
  output logic [AW-1:0]    o_target,
  output logic             o_link_we,
  output logic [RIW-1:0]   o_link_sel,
  output logic [DW-1:0]    o_link_data
);
  import br_pkg::*;

  localparam int NM = 2**CCW;

  br_kind_e      kind;
  logic          indexed;
  logic          hit;
  logic          r2_present;
  logic [AW-1:0] target_c;
  logic [DW-1:0] link_c;
  logic          taken_c;
  logic          link_we_c;
  logic [NM-1:0] mask;

  assign kind    = i_valid ? classify(i_opcode) : K_NONE;
  assign indexed = (kind == K_COND_IDX) || (kind == K_LINK_IDX);
  assign mask    = NM'(i_r1);

  br_cond_eval #(.CCW(CCW)) u_cond (
    .mask (mask),
    .cc   (i_cc),
    .hit  (hit)
  );

  br_addr_gen #(.AW(AW), .DW(DW), .DISPW(DISPW), .RIW(RIW)) u_addr (
    .indexed    (indexed),
    .x_fld      (i_x2),
    .b_fld      (i_b2),
    .r2_fld     (i_r2),
    .x_data     (i_x_data),
    .b_data     (i_b_data),
    .r2_data    (i_r2_data),
    .disp       (i_disp),
    .target     (target_c),
    .r2_present (r2_present)
  );

  br_link_pack #(.AW(AW), .DW(DW), .CCW(CCW), .PMW(PMW), .ILCW(ILCW)) u_link (
    .cur_addr (i_iaddr),
    .ilc      (i_ilc),
    .cc       (i_cc),
    .pmask    (i_pmask),
    .word     (link_c)
  );

  always_comb begin
    taken_c   = 1'b0;
    link_we_c = 1'b0;
    unique case (kind)
      K_COND_IDX: taken_c = hit;
      K_COND_REG: taken_c = hit && r2_present;
      K_LINK_IDX: begin
        taken_c   = 1'b1;
        link_we_c = 1'b1;
      end
      K_LINK_REG: begin
        taken_c   = r2_present;
        link_we_c = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_taken     <= 1'b0;
      o_target    <= '0;
      o_link_we   <= 1'b0;
      o_link_sel  <= '0;
      o_link_data <= '0;
    end else begin
      o_taken     <= taken_c;
      o_target    <= taken_c ? target_c : '0;
      o_link_we   <= link_we_c;
      o_link_sel  <= link_we_c ? i_r1 : '0;
      o_link_data <= link_we_c ? link_c : '0;
    end
  end
endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
  parameter int AW  = 24,
  parameter int DW  = 32,
  parameter int RIW = 4,
  parameter int CCW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           i_valid,
  input logic [7:0]     i_opcode,
  input logic [RIW-1:0] i_r1,
  input logic [RIW-1:0] i_r2,
  input logic [AW-1:0]  r2_low,
  input logic [CCW-1:0] i_cc,
  input logic           o_taken,
  input logic [AW-1:0]  o_target,
  input logic           o_link_we,
  input logic [RIW-1:0] o_link_sel,
  input logic [DW-1:0]  o_link_data
);
  logic is_link;
  logic is_known;

  assign is_link  = (i_opcode == 8'h45) || (i_opcode == 8'h05);
  assign is_known = is_link || (i_opcode == 8'h47) || (i_opcode == 8'h07);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !i_valid |=> (!o_taken && !o_link_we));

  // R2
  mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_opcode == 8'h47 && i_r1 == '0) |=> !o_taken);

  // R2
  mask_full_chk: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_opcode == 8'h47 && i_r1 == '1) |=> o_taken);

  // R5
  link_no_r2_chk: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_opcode == 8'h05 && i_r2 == '0) |=> (o_link_we && !o_taken));

  // R5
  link_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (i_valid && is_link) |=> (o_link_we && o_link_sel == $past(i_r1)));

  // R6
  link_cc_chk: assert property (@(posedge clk) disable iff (rst)
    (i_valid && is_link) |=> (o_link_data[DW-3:DW-4] == $past(i_cc)));

  // R4
  reg_target_chk: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_opcode == 8'h07 && i_r2 != '0 && i_r1 == '1) |=> (o_target == $past(r2_low)));

  // R7
  foreign_op_chk: assert property (@(posedge clk) disable iff (rst)
    (i_valid && !is_known) |=> (!o_taken && !o_link_we));

  // R8
  target_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !o_taken |-> (o_target == '0));
endmodule

bind br_resolve_unit br_resolve_chk #(.AW(AW), .DW(DW), .RIW(RIW), .CCW(CCW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .i_valid     (i_valid),
  .i_opcode    (i_opcode),
  .i_r1        (i_r1),
  .i_r2        (i_r2),
  .r2_low      (i_r2_data[AW-1:0]),
  .i_cc        (i_cc),
  .o_taken     (o_taken),
  .o_target    (o_target),
  .o_link_we   (o_link_we),
  .o_link_sel  (o_link_sel),
  .o_link_data (o_link_data)
);

// File: tb/test_br_resolve_unit.sv
`timescale 1ns/1ps
module test_br_resolve_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        i_valid = 1'b0;
  logic [7:0]  i_opcode = '0;
  logic [3:0]  i_r1 = '0, i_x2 = '0, i_b2 = '0, i_r2 = '0;
  logic [11:0] i_disp = '0;
  logic [31:0] i_x_data = '0, i_b_data = '0, i_r2_data = '0;
  logic [1:0]  i_cc = '0;
  logic [3:0]  i_pmask = '0;
  logic [1:0]  i_ilc = '0;
  logic [23:0] i_iaddr = '0;
  logic        o_taken, o_link_we;
  logic [23:0] o_target;
  logic [3:0]  o_link_sel;
  logic [31:0] o_link_data;

  int checks = 0;
  int errors = 0;
  string cur_req = "R9";
  string exp_req = "R9";
  logic        e_taken = 0, e_we = 0;
  logic [23:0] e_target = 0;
  logic [3:0]  e_sel = 0;
  logic [31:0] e_data = 0;
  bit done = 0;

  always #2 clk = ~clk;

  br_resolve_unit i_br_resolve_unit (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_opcode(i_opcode),
    .i_r1(i_r1), .i_x2(i_x2), .i_b2(i_b2), .i_r2(i_r2), .i_disp(i_disp),
    .i_x_data(i_x_data), .i_b_data(i_b_data), .i_r2_data(i_r2_data),
    .i_cc(i_cc), .i_pmask(i_pmask), .i_ilc(i_ilc), .i_iaddr(i_iaddr),
    .o_taken(o_taken), .o_target(o_target), .o_link_we(o_link_we),
    .o_link_sel(o_link_sel), .o_link_data(o_link_data)
  );

  // behavioural reference model, one clock of latency
  always @(posedge clk) begin
    longint sum;
    bit t, l;
    if (rst) begin
      e_taken <= 0; e_target <= 0; e_we <= 0; e_sel <= 0; e_data <= 0;
      exp_req <= cur_req;
    end else begin
      t = 0; l = 0; sum = 0;
      if (i_valid) begin
        if (i_opcode == 8'h47 || i_opcode == 8'h45) begin
          sum = i_disp;
          if (i_x2 != 0) sum = sum + (i_x_data % 32'h0100_0000);
          if (i_b2 != 0) sum = sum + (i_b_data % 32'h0100_0000);
        end else begin
          sum = i_r2_data % 32'h0100_0000;
        end
        if (i_opcode == 8'h47) t = i_r1[3 - i_cc];
        if (i_opcode == 8'h07) t = i_r1[3 - i_cc] && (i_r2 != 0);
        if (i_opcode == 8'h45) begin t = 1; l = 1; end
        if (i_opcode == 8'h05) begin t = (i_r2 != 0); l = 1; end
      end
      e_taken  <= t;
      e_target <= t ? 24'(sum % 64'h100_0000) : 24'd0;
      e_we     <= l;
      e_sel    <= l ? i_r1 : 4'd0;
      e_data   <= l ? ({30'd0, i_ilc} << 30) + ({30'd0, i_cc} << 28) + ({28'd0, i_pmask} << 24)
                      + 32'((i_iaddr + 2 * i_ilc) % 32'h0100_0000) : 32'd0;
      exp_req  <= cur_req;
    end
  end

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", exp_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("taken", 32'(o_taken), 32'(e_taken));
      cmp("target", 32'(o_target), 32'(e_target));
      cmp("link_we", 32'(o_link_we), 32'(e_we));
      cmp("link_sel", 32'(o_link_sel), 32'(e_sel));
      cmp("link_data", o_link_data, e_data);
    end
  end

  task automatic issue(input logic [7:0] op, input logic [3:0] r1, input logic [3:0] x2,
                       input logic [3:0] b2, input logic [3:0] r2, input logic [11:0] disp,
                       input logic [31:0] xd, input logic [31:0] bd, input logic [31:0] rd,
                       input logic [1:0] cc, input logic [3:0] pm, input logic [1:0] ilc,
                       input logic [23:0] ia, input string tag);
    @(negedge clk);
    cur_req = tag;
    i_valid = 1; i_opcode = op; i_r1 = r1; i_x2 = x2; i_b2 = b2; i_r2 = r2;
    i_disp = disp; i_x_data = xd; i_b_data = bd; i_r2_data = rd;
    i_cc = cc; i_pmask = pm; i_ilc = ilc; i_iaddr = ia;
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    cur_req = tag;
    i_valid = 0;
  endtask

  task automatic report();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    // R9: reset state, and an issue during reset is dropped
    repeat (3) @(negedge clk);
    issue(8'h45, 4'd3, 0, 0, 0, 12'h100, 0, 0, 0, 2'd1, 4'h5, 2'd2, 24'h1000, "R9");
    @(negedge clk); rst = 0;
    idle("R9"); idle("R8");
    // R1, R2: every mask against every condition code
    for (int m = 0; m < 16; m++)
      for (int c = 0; c < 4; c++)
        issue(8'h47, 4'(m), 4'd10, 4'd11, 0, 12'h050, 32'h5000, 32'h1000, 0,
              2'(c), 0, 2'd2, 24'h200, (m == 0 || m == 15) ? "R2" : "R1");
    idle("R8");
    // R3: operand fields of zero, and wrap modulo 2^24
    issue(8'h47, 4'hF, 0, 0, 1, 12'hABC, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 2'd2, 0, "R3");
    issue(8'h47, 4'hF, 4'd2, 0, 0, 12'h001, 32'hAB00_0010, 32'hFFFF_FFFF, 0, 0, 0, 2'd2, 0, "R3");
    issue(8'h47, 4'hF, 0, 4'd7, 0, 12'h002, 32'hFFFF_FFFF, 32'h12FF_FFFF, 0, 0, 0, 2'd2, 0, "R3");
    issue(8'h47, 4'hF, 4'd1, 4'd1, 0, 12'hFFF, 32'h00FF_F000, 32'h0000_1001, 0, 0, 0, 2'd2, 0, "R3");
    // R4: register forms
    issue(8'h07, 4'hF, 0, 0, 4'd0, 0, 0, 0, 32'h0012_3456, 2'd2, 0, 2'd1, 24'h300, "R4");
    issue(8'h07, 4'hF, 0, 0, 4'd9, 0, 0, 0, 32'hFF12_3456, 2'd2, 0, 2'd1, 24'h300, "R4");
    issue(8'h07, 4'h4, 0, 0, 4'd9, 0, 0, 0, 32'h0000_0800, 2'd2, 0, 2'd1, 24'h300, "R4");
    // R5, R6: link to register 0, link without branch, return address wrap
    issue(8'h45, 4'd0, 0, 4'd5, 0, 12'h010, 0, 32'h0000_1150, 0, 2'd3, 4'hA, 2'd2, 24'h0000C6, "R5");
    issue(8'h05, 4'd15, 0, 0, 4'd0, 0, 0, 0, 32'h777, 2'd1, 4'h3, 2'd1, 24'hFFFFFF, "R5");
    issue(8'h05, 4'd6, 0, 0, 4'd2, 0, 0, 0, 32'h00AB_CDEF, 2'd2, 4'hF, 2'd1, 24'h400, "R5");
    issue(8'h45, 4'd2, 4'd3, 4'd4, 0, 12'hFFF, 32'h00FF_FFFF, 32'h1, 0, 2'd0, 4'h1, 2'd3, 24'hFFFFFC, "R6");
    // R7: foreign opcodes with fields that would otherwise act
    issue(8'h46, 4'hF, 0, 0, 4'd1, 0, 0, 0, 32'h1234, 0, 0, 2'd2, 24'h10, "R7");
    issue(8'h06, 4'hF, 0, 0, 4'd1, 0, 0, 0, 32'h1234, 0, 0, 2'd1, 24'h10, "R7");
    issue(8'hC5, 4'hF, 0, 0, 4'd1, 0, 0, 0, 32'h1234, 0, 0, 2'd1, 24'h10, "R7");
    idle("R8");
    // mixed random traffic with idle gaps
    for (int k = 0; k < 400; k++) begin
      logic [7:0] ops [4] = '{8'h05, 8'h07, 8'h45, 8'h47};
      if ($urandom_range(0, 4) == 0) idle("R8");
      else issue(($urandom_range(0, 9) == 0) ? 8'(($urandom_range(0, 255))) : ops[$urandom_range(0, 3)],
                 4'($urandom), 4'($urandom_range(0, 3)), 4'($urandom_range(0, 3)),
                 4'($urandom_range(0, 3)), 12'($urandom), $urandom, $urandom, $urandom,
                 2'($urandom), 4'($urandom), 2'($urandom_range(1, 3)), 24'($urandom), "R8");
    end
    // R9: reset in the middle of traffic
    issue(8'h45, 4'd1, 0, 0, 0, 12'h20, 0, 0, 0, 0, 0, 2'd2, 24'h50, "R9");
    @(negedge clk); rst = 1; cur_req = "R9";
    i_opcode = 8'h47; i_r1 = 4'hF;
    idle("R9"); idle("R9");
    @(negedge clk); rst = 0;
    idle("R9"); idle("R9");
    report();
  end
endmodule